// File: doc/BRIEF.md
# Sector Clock and Set/Reset Router

This block routes clock and asynchronous set/reset to one sector of four register cells in one column of a fine-grained programmable array. A column clock is picked from eight global clock lines. When the block is built as a left-edge column it can also pick one of two fast clock pins. The sector then takes either that column clock or an express-line clock. It can invert the clock or gate it to a constant low. The set/reset signal for the sector comes from either the global set/reset line or an express line, and it can be inverted. A per-cell configuration bit decides whether an asserted set/reset drives that cell to 1 or to 0. Cells capture their data input on the rising edge of the final clock.

Configuration is held in a register on `cfg_clk`. It is written only while `cfg_we` is high. A three-state controller governs when the routing is live. `ST_POWER` is forced whenever `por_n` is low: all cells read 1 and the cell clock is low. When `por_n` rises, transition `POWER_DONE` moves to `ST_UNCONF`. In that state the clock stays gated low and set/reset is ignored. The first configuration write takes transition `FIRST_LOAD` to `ST_ACTIVE`, where the routing follows the configuration. Transition `POR_HIT` returns to `ST_POWER` from any state as soon as `por_n` falls. A write in `ST_ACTIVE` takes `RELOAD`, which stays in `ST_ACTIVE`.

Top module: `sector_clkrst_route`

## Requirements
- R1: Column clock select `cfg_data[3:0]`: codes 0 to 7 pick `gclk[code]`, code 8 picks `fclk[0]`, code 9 picks `fclk[1]`, and codes 10 to 15 give a constant low. Unselected lines have no effect on `q`.
- R2: Sector source bit `cfg_data[4]`: 0 takes the column clock and 1 takes `xclk`.
- R3: Inversion bit `cfg_data[6]`: when it is 1, the cells capture on the falling edge of the selected source instead of the rising edge.
- R4: Enable bit `cfg_data[5]`: when it is 0, the cell clock is constant low and no source activity changes `q`.
- R5: On each rising edge of the final cell clock, with set/reset inactive, `q[i]` takes `d[i]`.
- R6: Set/reset source bit `cfg_data[7]` picks `gsr_n` (0) or `xsr_n` (1). Polarity bit `cfg_data[8]`: when it is 0, a low line asserts; when it is 1, a high line asserts.
- R7: Set/reset acts at once, without a clock edge. Cell i goes to the value of mode bit `cfg_data[9+i]` (1 means set, 0 means reset), and a clock edge during assertion does not load `d`.
- R8: While `por_n` is low, `q` is 4'b1111 at once, the cell clock is low, and the configuration is cleared.
- R9: After `por_n` is released and before the first write, the cell clock stays low and set/reset has no effect. The first write enables the routing.
- R10: The configuration loads on a rising `cfg_clk` edge only when `cfg_we` is high; otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration and controller clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 13 | Configuration word |
| gclk | input | 8 | Global clock lines |
| fclk | input | 2 | Fast clock pins (left-edge variant) |
| xclk | input | 1 | Express-line clock |
| gsr_n | input | 1 | Global set/reset line |
| xsr_n | input | 1 | Express-line set/reset |
| d | input | 4 | Cell data inputs |
| q | output | 4 | Cell register outputs |

## Verification
A configuration write takes effect one `cfg_clk` rising edge after the strobe. The bench therefore updates its reference model and checks `q` 1 ns after that edge. Source-line, set/reset and power-on effects on `q` pass through no `cfg_clk` register, so they are due as soon as the line changes. The bench changes one line at a time, lets 1 ns pass, recomputes the final clock and set/reset levels in its model, and compares `q`. All changes are made right after a falling `cfg_clk` edge, so they never coincide with a controller update.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;
    localparam int NUM_GCK   = 8;
    localparam int NUM_FCK   = 2;
    localparam int NUM_CELLS = 4;
    localparam int SEL_W     = 4;
    localparam int NUM_SRC   = 1 << SEL_W;
    localparam int CFG_W     = SEL_W + 5 + NUM_CELLS;

    typedef struct packed {
        logic [NUM_CELLS-1:0] cell_set;  // per cell: 1 = set, 0 = reset
        logic                 sr_inv;
        logic                 sr_xp;
        logic                 clk_inv;
        logic                 clk_en;
        logic                 clk_xp;
        logic [SEL_W-1:0]     col_sel;
    } route_cfg_t;

    typedef enum logic [1:0] {
        ST_POWER  = 2'd0,
        ST_UNCONF = 2'd1,
        ST_ACTIVE = 2'd2
    } route_state_e;
endpackage

// File: rtl/scr_cfg_ctrl.sv
`timescale 1ns/1ps
module scr_cfg_ctrl
    import scr_pkg::*;
(
    input  logic                 cfg_clk,
    input  logic                 por_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_data,
    output route_cfg_t           cfg_q,
    output route_state_e         state,
    output logic                 live
);
    route_state_e state_nx;

    // state register; POR_HIT is the asynchronous path into ST_POWER
    always_ff @(posedge cfg_clk or negedge por_n) begin
        if (!por_n) state <= ST_POWER;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWER:  state_nx = ST_UNCONF;                        // POWER_DONE
            ST_UNCONF: state_nx = cfg_we ? ST_ACTIVE : ST_UNCONF;   // FIRST_LOAD
            ST_ACTIVE: state_nx = ST_ACTIVE;                        // RELOAD or hold
            default:   state_nx = ST_POWER;
        endcase
    end

    // output process
    always_comb begin
        live = (state == ST_ACTIVE);
    end

    always_ff @(posedge cfg_clk or negedge por_n) begin
        if (!por_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= route_cfg_t'(cfg_data);
    end

    p_load_cfg_r10: assert property (@(posedge cfg_clk) disable iff (!por_n)
        cfg_we |=> (cfg_q == route_cfg_t'($past(cfg_data))));
    p_hold_cfg_r10: assert property (@(posedge cfg_clk) disable iff (!por_n)
        !cfg_we |=> $stable(cfg_q));
    p_unconf_stays_r9: assert property (@(posedge cfg_clk) disable iff (!por_n)
        (state == ST_UNCONF && !cfg_we) |=> (state == ST_UNCONF));
    p_first_load_r9: assert property (@(posedge cfg_clk) disable iff (!por_n)
        (state == ST_UNCONF && cfg_we) |=> (state == ST_ACTIVE));
endmodule

// File: rtl/scr_col_mux.sv
`timescale 1ns/1ps
module scr_col_mux
    import scr_pkg::*;
#(
    parameter bit LEFT_EDGE = 1'b1
) (
    input  logic [NUM_GCK-1:0] gclk,
    input  logic [NUM_FCK-1:0] fclk,
    input  logic [SEL_W-1:0]   col_sel,
    output logic               col_clk
);
    localparam int PAD_W = NUM_SRC - NUM_GCK - NUM_FCK;
    logic [NUM_SRC-1:0] src_vec;

    generate
        if (LEFT_EDGE) begin : g_left
            assign src_vec = {{PAD_W{1'b0}}, fclk, gclk};
        end else begin : g_inner
            assign src_vec = {{(PAD_W + NUM_FCK){1'b0}}, gclk};
        end
    endgenerate

    always_comb begin
        col_clk = src_vec[col_sel];
    end
endmodule

// File: rtl/scr_sector_path.sv
`timescale 1ns/1ps
module scr_sector_path
    import scr_pkg::*;
(
    input  logic       col_clk,
    input  logic       xclk,
    input  logic       gsr_n,
    input  logic       xsr_n,
    input  route_cfg_t cfg,
    input  logic       live,
    output logic       cell_clk,
    output logic       sr_n_eff
);
    logic clk_pick, clk_pol, sr_pick;

    always_comb begin
        clk_pick = cfg.clk_xp ? xclk : col_clk;
        clk_pol  = clk_pick ^ cfg.clk_inv;
        cell_clk = live & cfg.clk_en & clk_pol;
        sr_pick  = cfg.sr_xp ? xsr_n : gsr_n;
        sr_n_eff = live ? (sr_pick ^ cfg.sr_inv) : 1'b1;
    end
endmodule

// File: rtl/scr_cell_bank.sv
`timescale 1ns/1ps
module scr_cell_bank
    import scr_pkg::*;
(
    input  logic                 cell_clk,
    input  logic                 por_n,
    input  logic                 sr_n_eff,
    input  logic [NUM_CELLS-1:0] cell_set,
    input  logic [NUM_CELLS-1:0] d,
    output logic [NUM_CELLS-1:0] q
);
    generate
        for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
            always_ff @(posedge cell_clk or negedge por_n or negedge sr_n_eff) begin
                if (!por_n)         q[i] <= 1'b1;
                else if (!sr_n_eff) q[i] <= cell_set[i];
                else                q[i] <= d[i];
            end
        end
    endgenerate
endmodule

// File: rtl/sector_clkrst_route.sv
`timescale 1ns/1ps
module sector_clkrst_route
    import scr_pkg::*;
#(
    parameter bit LEFT_EDGE = 1'b1
) (
    input  logic                 cfg_clk,
    input  logic                 por_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic [NUM_GCK-1:0]   gclk,
    input  logic [NUM_FCK-1:0]   fclk,
    input  logic                 xclk,
    input  logic                 gsr_n,
    input  logic                 xsr_n,
    input  logic [NUM_CELLS-1:0] d,
    output logic [NUM_CELLS-1:0] q
);
    route_cfg_t   cfg_q;
    route_state_e state;
    logic         live, col_clk, cell_clk, sr_n_eff;

    scr_cfg_ctrl u_ctrl (
        .cfg_clk (cfg_clk), .por_n (por_n), .cfg_we (cfg_we),
        .cfg_data(cfg_data), .cfg_q (cfg_q), .state (state), .live (live)
    );

    scr_col_mux #(.LEFT_EDGE(LEFT_EDGE)) u_mux (
        .gclk(gclk), .fclk(fclk), .col_sel(cfg_q.col_sel), .col_clk(col_clk)
    );

    scr_sector_path u_path (
        .col_clk(col_clk), .xclk(xclk), .gsr_n(gsr_n), .xsr_n(xsr_n),
        .cfg(cfg_q), .live(live), .cell_clk(cell_clk), .sr_n_eff(sr_n_eff)
    );

    scr_cell_bank u_cells (
        .cell_clk(cell_clk), .por_n(por_n), .sr_n_eff(sr_n_eff),
        .cell_set(cfg_q.cell_set), .d(d), .q(q)
    );

    p_por_ones_r8: assert property (@(posedge cfg_clk)
        !por_n |-> (q == {NUM_CELLS{1'b1}}));
    p_gated_clk_r9: assert property (@(posedge cfg_clk) disable iff (!por_n)
        (state != ST_ACTIVE) |-> !cell_clk);
    p_gated_sr_r9: assert property (@(posedge cfg_clk) disable iff (!por_n)
        (state != ST_ACTIVE) |-> sr_n_eff);
    p_disabled_low_r4: assert property (@(posedge cfg_clk) disable iff (!por_n)
        !cfg_q.clk_en |-> !cell_clk);
endmodule

// File: tb/test_sector_clkrst_route.sv
`timescale 1ns/1ps
module test_sector_clkrst_route;
    logic        cfg_clk = 1'b0;
    logic        por_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_data = '0;
    logic [7:0]  gclk = '0;
    logic [1:0]  fclk = '0;
    logic        xclk = 1'b0;
    logic        gsr_n = 1'b1;
    logic        xsr_n = 1'b1;
    logic [3:0]  d = '0;
    logic [3:0]  q;

    sector_clkrst_route i_sector_clkrst_route (
        .cfg_clk(cfg_clk), .por_n(por_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .gclk(gclk), .fclk(fclk), .xclk(xclk), .gsr_n(gsr_n), .xsr_n(xsr_n),
        .d(d), .q(q)
    );

    always #2 cfg_clk = ~cfg_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [12:0] m_cfg = '0;
    bit          m_live = 1'b0;
    logic [3:0]  m_q = 4'b1111;
    logic        p_clk = 1'b0;
    logic        p_sr = 1'b1;

    function automatic logic mdl_clk();
        logic [3:0] sel = m_cfg[3:0];
        logic src;
        if (sel < 4'd8)       src = gclk[sel[2:0]];
        else if (sel == 4'd8) src = fclk[0];
        else if (sel == 4'd9) src = fclk[1];
        else                  src = 1'b0;
        if (m_cfg[4]) src = xclk;
        return m_live & m_cfg[5] & (src ^ m_cfg[6]);
    endfunction

    function automatic logic mdl_sr();
        logic line = m_cfg[7] ? xsr_n : gsr_n;
        return m_live ? (line ^ m_cfg[8]) : 1'b1;
    endfunction

    task automatic apply();
        logic nc, ns;
        #1;
        nc = mdl_clk();
        ns = mdl_sr();
        if (!por_n) m_q = 4'b1111;
        else if ((!p_clk && nc) || (p_sr && !ns)) m_q = ns ? d : m_cfg[12:9];
        p_clk = nc;
        p_sr  = ns;
    endtask

    task automatic chk(string req);
        n_chk++;
        if (q !== m_q) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b (cfg=%b)", req, q, m_q, m_cfg);
        end
    endtask

    task automatic wr(logic [12:0] v, bit we, string req);
        @(negedge cfg_clk);
        cfg_data = v;
        cfg_we = we;
        @(posedge cfg_clk);
        if (we && por_n) begin
            m_cfg = v;
            m_live = 1'b1;
        end
        apply();
        cfg_we = 1'b0;
        chk(req);
    endtask

    task automatic set_line(int k, logic v, string req);
        @(negedge cfg_clk);
        if (k < 8)        gclk[k] = v;
        else if (k < 10)  fclk[k-8] = v;
        else if (k == 10) xclk = v;
        else if (k == 11) gsr_n = v;
        else              xsr_n = v;
        apply();
        chk(req);
    endtask

    task automatic pulse_all_clocks(string req);
        for (int k = 0; k < 11; k++) begin
            set_line(k, 1'b1, req);
            set_line(k, 1'b0, req);
        end
    endtask

    // {cfg[12:0], dA, dB}; cfg = {set[3:0], sr_inv, sr_xp, clk_inv, clk_en, clk_xp, sel[3:0]}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {4'b1010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3,  4'b0101, 4'b1100},
        {4'b0101, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7,  4'b0011, 4'b1001},
        {4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  4'b0000, 4'b0110},
        {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8,  4'b1110, 4'b0001},
        {4'b1100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9,  4'b0100, 4'b1011},
        {4'b0011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd12, 4'b1010, 4'b0101},
        {4'b1001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5,  4'b0111, 4'b1000},
        {4'b0110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1,  4'b1101, 4'b0010},
        {4'b0110, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4,  4'b0001, 4'b1110},
        {4'b1001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2,  4'b1011, 4'b0100}
    };

    initial begin
        #1 por_n = 1'b0;
        apply();
        #3;
        chk("R8 reset state");
        @(negedge cfg_clk);
        por_n = 1'b1;
        @(posedge cfg_clk);
        apply();
        chk("R9 after release");

        // unconfigured: clocks and set/reset ignored
        d = 4'b0000;
        set_line(0, 1'b1, "R9 clock gated");
        set_line(0, 1'b0, "R9 clock gated");
        set_line(11, 1'b0, "R9 sr ignored");
        set_line(11, 1'b1, "R9 sr ignored");
        // write without strobe must not configure
        wr({4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0}, 1'b0, "R10 no strobe");
        set_line(0, 1'b1, "R10 still unconfigured");
        set_line(0, 1'b0, "R10 still unconfigured");

        // table walk
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][20:8], 1'b1, "R10 load");
            d = VEC[v][7:4];
            pulse_all_clocks("R1 R2 R3 R4 R5 dA");
            d = VEC[v][3:0];
            pulse_all_clocks("R1 R2 R3 R4 R5 dB");
            set_line(11, 1'b0, "R6 R7 gsr low");
            set_line(11, 1'b1, "R6 R7 gsr high");
            set_line(12, 1'b0, "R6 R7 xsr low");
            set_line(12, 1'b1, "R6 R7 xsr high");
        end

        // R7: held set/reset beats a clock edge (reset mode 0000, sr via gsr_n active low)
        wr({4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6}, 1'b1, "R7 setup");
        d = 4'b1111;
        set_line(6, 1'b1, "R5 capture");
        set_line(6, 1'b0, "R5 capture");
        set_line(11, 1'b0, "R7 async reset");
        set_line(6, 1'b1, "R7 edge during assert");
        set_line(6, 1'b0, "R7 edge during assert");
        set_line(11, 1'b1, "R7 release");

        // R10: new data without strobe is ignored, old select stays in use
        wr({4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1}, 1'b0, "R10 no strobe");
        d = 4'b1010;
        set_line(1, 1'b1, "R10 old select");
        set_line(1, 1'b0, "R10 old select");
        set_line(6, 1'b1, "R10 old select");
        set_line(6, 1'b0, "R10 old select");

        // R8 mid-run power-on, then R9 gating again
        @(negedge cfg_clk);
        por_n = 1'b0;
        m_live = 1'b0;
        m_cfg = '0;
        apply();
        chk("R8 por mid-run");
        set_line(6, 1'b1, "R8 clock held low");
        set_line(6, 1'b0, "R8 clock held low");
        @(negedge cfg_clk);
        por_n = 1'b1;
        @(posedge cfg_clk);
        apply();
        chk("R9 release");
        d = 4'b0000;
        set_line(0, 1'b1, "R9 gated after release");
        set_line(0, 1'b0, "R9 gated after release");
        wr({4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0}, 1'b1, "R9 first load");
        set_line(0, 1'b1, "R9 live after load");
        set_line(0, 1'b0, "R9 live after load");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule